// File: doc/BRIEF.md
# Multiplier-Free Bit-Serial FIR Inner Product

This block produces one output of a fixed-coefficient FIR filter without a single multiplier. A short delay line keeps the most recent `NTAPS` input samples. When a computation starts, the line is copied into a working snapshot. The block then walks through the samples' bit positions from least to most significant. On each step, the bit at the current position of every tap forms an `NTAPS`-bit address. That address selects, from a constant table, the sum of the coefficients whose taps have a one at that position. The block shifts and accumulates these partial sums. The slice at the sign position carries negative weight in two's complement, so its partial sum is subtracted.

The table has `2**NTAPS` signed entries. It is built at elaboration time by a constant function of the coefficient parameter. A decimating filter with ratio M has only M cycles for each output, so `BPC` bit positions can be handled per cycle. Each extra position uses its own copy of the table, which divides the cycle count by `BPC`. The accumulator runs from right to left. Each cycle it shifts arithmetically right by `BPC` and adds the new weighted slice sum at the top. This keeps every low-order bit, so the final value is exact.

Top module: `da_inner_product`

## Requirements
- R1: While reset is high and after reset is released, `done` is 0 and `result` is 0 until the first computation completes.
- R2: Each cycle with `smp_valid` high shifts `smp_data` into the delay line. The newest sample is tap 0, and the sample pushed i pushes earlier is tap i. A completed computation returns `result = sum over i of h_i * x_i`, where samples and coefficients are two's-complement numbers. Coefficient h_i sits in bits `[i*CW +: CW]` of `COEFS`.
- R3: If `start` is sampled high at clock edge t while the block is idle, `done` is high for exactly the one cycle that follows edge t + XW/BPC.
- R4: `result` changes only together with a `done` pulse, and holds its value between completions.
- R5: The most significant bit of each sample carries weight −2^(XW−1). Negative samples, including the most negative value, give the exact signed product sum.
- R6: A `start` that arrives while a computation is running is ignored. It neither restarts the computation nor causes a second `done` pulse.
- R7: Samples that are pushed while a computation runs do not affect that computation's result. They do enter the delay line and are used by the next start.
- R8: With `BPC` = 2, the block uses two table copies and gives the same results as with `BPC` = 1, in XW/2 cycles.
- R9: The accumulator is `CW + XW + clog2(NTAPS) + 1` bits wide. The most negative coefficients and samples produce exact results without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Push `smp_data` into the delay line |
| smp_data | input | XW | New two's-complement sample |
| start | input | 1 | Snapshot the delay line and begin a computation (ignored when busy) |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | CW+XW+clog2(NTAPS)+1 | Signed inner product, held until the next completion |

## Verification
The assertions check the following on every cycle. `done` follows an accepted start by exactly XW/BPC cycles, tracked with a counter in the checker. `done` never lasts longer than one cycle. A running computation ends only through `done`. `result` never moves without `done`. Numerical correctness can only be shown by the bench's scenarios. The bench compares results against a multiply-accumulate model for mixed-sign, most-negative and all-maximum samples. It also pushes samples and pulses `start` in the middle of a run, and it checks that two instances with one and two bits per cycle agree.

// File: rtl/da_pkg.sv
package da_pkg;
  typedef enum logic {DA_IDLE, DA_RUN} da_state_e;
endpackage

// File: rtl/da_sample_line.sv
module da_sample_line #(
  parameter int NTAPS = 4,
  parameter int XW    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  push,
  input  logic [XW-1:0]         din,
  output logic [NTAPS*XW-1:0]   taps
);
  logic [XW-1:0] line_q [NTAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAPS; i++) line_q[i] <= '0;
    end else if (push) begin
      line_q[0] <= din;
      for (int i = 1; i < NTAPS; i++) line_q[i] <= line_q[i-1];
    end
  end

  for (genvar i = 0; i < NTAPS; i++) begin : g_flat
    assign taps[i*XW +: XW] = line_q[i];
  end
endmodule

// File: rtl/da_lut.sv
module da_lut #(
  parameter int                     NTAPS = 4,
  parameter int                     CW    = 8,
  parameter int                     TW    = 10,
  parameter logic [NTAPS*CW-1:0]    COEFS = '0
) (
  input  logic [NTAPS-1:0]          addr,
  output logic signed [TW-1:0]      value
);
  localparam int DEPTH = 2 ** NTAPS;

  function automatic logic signed [TW-1:0] entry(input int a);
    logic signed [TW-1:0] s;
    logic signed [CW-1:0] c;
    s = '0;
    for (int i = 0; i < NTAPS; i++) begin
      c = COEFS[i*CW +: CW];
      if (((a >> i) & 1) != 0) s = s + TW'(c);
    end
    return s;
  endfunction

  logic signed [TW-1:0] rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_rom
    assign rom[a] = entry(a);
  end

  assign value = rom[addr];
endmodule

// File: rtl/da_accum.sv
module da_accum #(
  parameter int BPC   = 1,
  parameter int TW    = 10,
  parameter int AW    = 19,
  parameter int SHIFT = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  en,
  input  logic                  last,
  input  logic [BPC*TW-1:0]     parts,
  output logic signed [AW-1:0]  acc_next
);
  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] slice_sum;

  always_comb begin
    logic signed [TW-1:0] f;
    logic signed [AW-1:0] term;
    slice_sum = '0;
    for (int j = 0; j < BPC; j++) begin
      f    = parts[j*TW +: TW];
      term = AW'(f) <<< j;
      if (last && (j == BPC - 1)) slice_sum = slice_sum - term;
      else                        slice_sum = slice_sum + term;
    end
    acc_next = (acc_q >>> BPC) + (slice_sum <<< SHIFT);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else if (en)      acc_q <= acc_next;
  end
endmodule

// File: rtl/da_inner_product.sv
module da_inner_product #(
  parameter int                  NTAPS = 4,
  parameter int                  XW    = 8,
  parameter int                  CW    = 8,
  parameter int                  BPC   = 1,
  parameter logic [NTAPS*CW-1:0] COEFS = 32'h8064F903,
  localparam int                 AW    = CW + XW + $clog2(NTAPS) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [XW-1:0] smp_data,
  input  logic          start,
  output logic          done,
  output logic [AW-1:0] result
);
  import da_pkg::*;

  localparam int TW    = CW + $clog2(NTAPS);
  localparam int NCYC  = XW / BPC;
  localparam int CNTW  = (NCYC > 1) ? $clog2(NCYC) : 1;
  localparam int SHIFT = XW - BPC;

  da_state_e                  state_q;
  logic                       busy_q;
  logic [CNTW-1:0]            cnt_q;
  logic [NTAPS*XW-1:0]        taps;
  logic [NTAPS*XW-1:0]        snap_q;
  logic                       accept;
  logic                       last;
  logic [NTAPS-1:0]           addr [BPC];
  logic [BPC*TW-1:0]          parts;
  logic signed [AW-1:0]       acc_next;
  logic                       done_q;
  logic [AW-1:0]              result_q;

  assign busy_q = (state_q == DA_RUN);
  assign accept = start && !busy_q;
  assign last   = busy_q && (int'(cnt_q) == NCYC - 1);

  da_sample_line #(.NTAPS(NTAPS), .XW(XW)) u_line (
    .clk(clk), .rst(rst), .push(smp_valid), .din(smp_data), .taps(taps)
  );

  always_comb begin
    for (int j = 0; j < BPC; j++) begin
      for (int i = 0; i < NTAPS; i++) begin
        addr[j][i] = snap_q[i*XW + int'(cnt_q)*BPC + j];
      end
    end
  end

  for (genvar j = 0; j < BPC; j++) begin : g_copy
    logic signed [TW-1:0] val;
    da_lut #(.NTAPS(NTAPS), .CW(CW), .TW(TW), .COEFS(COEFS)) u_lut (
      .addr(addr[j]), .value(val)
    );
    assign parts[j*TW +: TW] = val;
  end

  da_accum #(.BPC(BPC), .TW(TW), .AW(AW), .SHIFT(SHIFT)) u_acc (
    .clk(clk), .rst(rst), .clear(accept), .en(busy_q), .last(last),
    .parts(parts), .acc_next(acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= DA_IDLE;
      cnt_q    <= '0;
      snap_q   <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= DA_RUN;
        cnt_q   <= '0;
        snap_q  <= taps;
      end else if (busy_q) begin
        if (last) begin
          state_q  <= DA_IDLE;
          done_q   <= 1'b1;
          result_q <= acc_next;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign done   = done_q;
  assign result = result_q;
endmodule

// File: rtl/da_inner_product_chk.sv
module da_inner_product_chk #(
  parameter int NCYC = 8,
  parameter int AW   = 19
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] result
);
  logic [31:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst)                lat_q <= '0;
    else if (start && !busy) lat_q <= '0;
    else if (busy)          lat_q <= lat_q + 1;
  end

  a_r3_done_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_q == NCYC));

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r4_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  a_r6_run_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  a_r1_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind da_inner_product da_inner_product_chk #(.NCYC(NCYC), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy_q), .done(done), .result(result)
);

// File: tb/test_da_inner_product.sv
`timescale 1ns/1ps
module test_da_inner_product;
  localparam int NTAPS = 4;
  localparam int XW    = 8;
  localparam int CW    = 8;
  localparam int AW    = CW + XW + $clog2(NTAPS) + 1;
  localparam logic [NTAPS*CW-1:0] COEFS = 32'h8064F903;

  int h [NTAPS] = '{3, -7, 100, -128};
  int mdl [NTAPS];
  int n_run = 0;
  int n_fail = 0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [XW-1:0] smp_data = '0;
  logic start = 1'b0;
  logic done_a, done_b;
  logic [AW-1:0] result_a, result_b;

  always #4 clk = ~clk;

  da_inner_product #(.NTAPS(NTAPS), .XW(XW), .CW(CW), .BPC(1), .COEFS(COEFS)) i_da_inner_product (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .start(start), .done(done_a), .result(result_a)
  );

  da_inner_product #(.NTAPS(NTAPS), .XW(XW), .CW(CW), .BPC(2), .COEFS(COEFS)) i_da_inner_product_b2 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .start(start), .done(done_b), .result(result_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  function automatic int ref_sum();
    int s = 0;
    for (int i = 0; i < NTAPS; i++) s += h[i] * mdl[i];
    return s;
  endfunction

  task automatic push(input int v);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = XW'(v);
    @(negedge clk);
    smp_valid = 1'b0;
    for (int i = NTAPS - 1; i > 0; i--) mdl[i] = mdl[i-1];
    mdl[0] = v;
  endtask

  task automatic run_check(input int exp_v, input string req);
    int na = 0;
    int nb = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (done_a && na == 0) na = n;
      if (done_b && nb == 0) nb = n;
      if (na != 0 && nb != 0) break;
    end
    chk(na == XW, {req, " R3 latency"}, na, XW);
    chk(nb == XW/2, {req, " R8 latency"}, nb, XW/2);
    chk(int'($signed(result_a)) == exp_v, {req, " result"}, int'($signed(result_a)), exp_v);
    chk(int'($signed(result_b)) == exp_v, {req, " R8 result"}, int'($signed(result_b)), exp_v);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NTAPS; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    chk(done_a == 1'b0 && result_a == '0, "R1 in reset", int'(result_a), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(done_a == 1'b0 && done_b == 1'b0, "R1 done after reset", int'(done_a), 0);
    chk(result_a == '0 && result_b == '0, "R1 result after reset", int'(result_b), 0);
  endtask

  task automatic t_basic();
    push(5); push(-3); push(17); push(2);
    run_check(ref_sum(), "R2 mixed");
    push(1); push(0); push(0); push(0);
    run_check(ref_sum(), "R2 single tap");
  endtask

  task automatic t_negative();
    push(-128); push(-1); push(64); push(-77);
    run_check(ref_sum(), "R5 negative samples");
  endtask

  task automatic t_extremes();
    for (int i = 0; i < NTAPS; i++) push(-128);
    run_check(ref_sum(), "R9 all most negative");
    for (int i = 0; i < NTAPS; i++) push(127);
    run_check(ref_sum(), "R9 all max");
  endtask

  task automatic t_hold();
    int keep_a = int'($signed(result_a));
    int seen = 0;
    push(33); push(-44);
    repeat (10) begin
      @(negedge clk);
      if (done_a || done_b) seen++;
    end
    chk(seen == 0, "R4 no done without start", seen, 0);
    chk(int'($signed(result_a)) == keep_a, "R4 result held", int'($signed(result_a)), keep_a);
  endtask

  task automatic t_busy_start();
    int exp_old, na, nb, extra;
    push(9); push(-20); push(111); push(-6);
    exp_old = ref_sum();
    na = 0; nb = 0; extra = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (n == 1) begin
        start = 1'b1; smp_valid = 1'b1; smp_data = XW'(-99);
      end else if (n == 2) begin
        start = 1'b0; smp_valid = 1'b0;
      end
      if (done_a && na == 0) na = n;
      if (done_b && nb == 0) nb = n;
      if (na != 0 && nb != 0) break;
    end
    for (int i = NTAPS - 1; i > 0; i--) mdl[i] = mdl[i-1];
    mdl[0] = -99;
    chk(na == XW, "R6 latency unchanged by busy start", na, XW);
    chk(nb == XW/2, "R6 R8 latency unchanged", nb, XW/2);
    chk(int'($signed(result_a)) == exp_old, "R7 snapshot result", int'($signed(result_a)), exp_old);
    chk(int'($signed(result_b)) == exp_old, "R7 R8 snapshot result", int'($signed(result_b)), exp_old);
    repeat (XW + 2) begin
      @(negedge clk);
      if (done_a || done_b) extra++;
    end
    chk(extra == 0, "R6 no second done", extra, 0);
    run_check(ref_sum(), "R7 new sample used next");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_negative();
    t_extremes();
    t_hold();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule